// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. After a transfer has been cut short by a reset, a brown-out or a software abort, a target device may still be in the middle of a byte and may be holding the data line low. A single request pulse makes the sequencer drive both open-drain lines through a fixed recovery pattern. The pattern is a start condition, nine clock pulses with the data line released, a second start condition, and then a stop condition. Any target left mid-byte can shift out its remaining bits during the nine pulses. The second start followed by the stop then puts every target back into its idle protocol state.

Each line is driven only by a pull-low enable: 1 pulls the line low and 0 releases it to the external pull-up. Every phase length is a parameter counted in system clock cycles. This lets the integrator meet the bus minimums at any clock rate: 1.3 us clock low, 0.6 us clock high, 0.6 us for start setup, start hold and stop setup, and 1.3 us of free bus. The defaults suit a 125 MHz clock. The sequencer shows `busy` while the pattern runs and pulses `done` once when the closing bus-free interval ends. It does not transfer data, arbitrate or honour clock stretching.

Top module: `bus_recover_seq`

## Requirements
- R1: While reset is high, and in the cycle after any clock edge that samples reset high, `scl_low`, `sda_low`, `busy` and `done` are all 0.
- R2: A clock edge that samples `req` high while `busy` is 0 sets `busy` to 1. For the following T_SU_STA cycles, both lines stay released.
- R3: SDA is then pulled low (`sda_low`=1) with SCL released for T_HD_STA cycles, which forms the first start. After that, SCL is also pulled low for T_TURN cycles while SDA stays low.
- R4: Next come N_PULSES clock pulses. Each pulse is T_LOW cycles with `scl_low`=1 followed by T_HIGH cycles with `scl_low`=0. `sda_low` stays 0 through every pulse, and exactly N_PULSES rising SCL edges occur between the two starts.
- R5: After the last pulse, SCL stays released for T_SU_STA further cycles. SDA is then pulled low with SCL released for T_HD_STA cycles, which forms the second start.
- R6: SCL stays released and SDA is held low for T_SU_STO further cycles. SDA is then released while SCL is high, which forms the stop.
- R7: Both lines then stay released for T_BUF cycles. In the cycle after that, `busy` is 0 and `done` is 1. `done` is 1 for exactly that one cycle, and both lines stay released whenever `busy` is 0.
- R8: A `req` sampled while `busy` is 1 has no effect on the running pattern and does not extend it. A `req` that is still high in the `done` cycle starts a new pattern at the next edge.
- R9: The two pull-low enables never change in the same cycle.
- R10: With the default parameters and a 125 MHz clock, the measured SCL low time is at least 1300 ns and the SCL high time at least 600 ns. Start setup, start hold and stop setup are each at least 600 ns, and the bus is free for at least 1300 ns before `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request to run the recovery pattern, sampled when idle |
| scl_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_low | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Pattern in progress |
| done | output | 1 | One-cycle pulse when the pattern has fully ended |

## Verification
The bench tries the pattern under four request styles:
- A one-cycle pulse from idle shows the complete phase sequence on its own.
- A second pulse fired mid-pattern must leave that sequence untouched, which separates a sequencer that samples only when idle from one that restarts.
- A request held high across the `done` cycle shows whether a back-to-back run begins exactly one edge after `done`.
- A reset that lands while both lines are pulled low, followed by a fresh run, shows whether the pulse count and phase timer truly clear and do not carry stale state into the next pattern.

On top of the per-cycle comparison, the bench measures the bus waveform in nanoseconds. Every low, high, setup, hold and bus-free interval is checked against the protocol minimums, and the bench counts the clock pulses between the two starts.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SU1,
    PH_HD1,
    PH_TURN,
    PH_LOW,
    PH_HIGH,
    PH_SU2,
    PH_HD2,
    PH_STO,
    PH_BUF
  } brs_phase_e;

  // Returns {scl pull-low, sda pull-low} for a phase.
  function automatic logic [1:0] brs_drive(brs_phase_e p);
    case (p)
      PH_HD1, PH_HD2, PH_STO: brs_drive = 2'b01;
      PH_TURN:                brs_drive = 2'b11;
      PH_LOW:                 brs_drive = 2'b10;
      default:                brs_drive = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/brs_timer.sv
module brs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear || last) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/brs_pulse_cnt.sv
module brs_pulse_cnt #(
  parameter int N_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic final_pulse
);
  localparam int PW = $clog2(N_PULSES + 1);

  logic [PW-1:0] pc;

  assign final_pulse = (pc == PW'(N_PULSES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) pc <= '0;
    else if (tick)    pc <= pc + 1'b1;
  end
endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
  import brs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       last,
  input  logic       final_pulse,
  output brs_phase_e ph,
  output brs_phase_e ph_nxt
);
  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE: if (req)  ph_nxt = PH_SU1;
      PH_SU1:  if (last) ph_nxt = PH_HD1;
      PH_HD1:  if (last) ph_nxt = PH_TURN;
      PH_TURN: if (last) ph_nxt = PH_LOW;
      PH_LOW:  if (last) ph_nxt = PH_HIGH;
      PH_HIGH: if (last) ph_nxt = final_pulse ? PH_SU2 : PH_LOW;
      PH_SU2:  if (last) ph_nxt = PH_HD2;
      PH_HD2:  if (last) ph_nxt = PH_STO;
      PH_STO:  if (last) ph_nxt = PH_BUF;
      PH_BUF:  if (last) ph_nxt = PH_IDLE;
      default:           ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else     ph <= ph_nxt;
  end
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import brs_pkg::*;
#(
  parameter int T_SU_STA = 80,
  parameter int T_HD_STA = 80,
  parameter int T_TURN   = 8,
  parameter int T_LOW    = 168,
  parameter int T_HIGH   = 80,
  parameter int T_SU_STO = 80,
  parameter int T_BUF    = 168,
  parameter int N_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic scl_low,
  output logic sda_low,
  output logic busy,
  output logic done
);
  localparam int M1   = (T_SU_STA > T_HD_STA) ? T_SU_STA : T_HD_STA;
  localparam int M2   = (T_TURN > T_LOW) ? T_TURN : T_LOW;
  localparam int M3   = (T_HIGH > T_SU_STO) ? T_HIGH : T_SU_STO;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > T_BUF) ? M3 : T_BUF;
  localparam int TMAX = (M4 > M5) ? M4 : M5;
  localparam int CW   = $clog2(TMAX + 1);

  brs_phase_e    ph, ph_nxt;
  logic [CW-1:0] len;
  logic          last, final_pulse;
  logic          in_idle, pulse_end;

  assign in_idle   = (ph == PH_IDLE);
  assign pulse_end = (ph == PH_HIGH) && last;

  always_comb begin
    case (ph)
      PH_SU1, PH_SU2: len = CW'(T_SU_STA);
      PH_HD1, PH_HD2: len = CW'(T_HD_STA);
      PH_TURN:        len = CW'(T_TURN);
      PH_LOW:         len = CW'(T_LOW);
      PH_HIGH:        len = CW'(T_HIGH);
      PH_STO:         len = CW'(T_SU_STO);
      PH_BUF:         len = CW'(T_BUF);
      default:        len = CW'(1);
    endcase
  end

  brs_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (in_idle),
    .len   (len),
    .last  (last)
  );

  brs_pulse_cnt #(.N_PULSES(N_PULSES)) u_pulses (
    .clk         (clk),
    .rst         (rst),
    .clear       (in_idle),
    .tick        (pulse_end),
    .final_pulse (final_pulse)
  );

  brs_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .last        (last),
    .final_pulse (final_pulse),
    .ph          (ph),
    .ph_nxt      (ph_nxt)
  );

  // Outputs are registered from the next phase so they align with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      {scl_low, sda_low} <= brs_drive(ph_nxt);
      busy               <= (ph_nxt != PH_IDLE);
      done               <= (ph == PH_BUF) && last;
    end
  end
endmodule

// File: rtl/brs_checker.sv
module brs_checker (
  input logic clk,
  input logic rst,
  input logic req,
  input logic scl_low,
  input logic sda_low,
  input logic busy,
  input logic done
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done && !scl_low && !sda_low)); // R1

  AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (rst)
    (!busy && req) |=> busy); // R2

  AST_SDA_FREE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    (scl_low && !sda_low) |=> !sda_low); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_low && !sda_low)); // R7

  AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (rst)
    !((scl_low != $past(scl_low)) && (sda_low != $past(sda_low)))); // R9
endmodule

bind bus_recover_seq brs_checker u_brs_checker (.*);

// File: tb/bus_recover_seq_bench.sv
module bus_recover_seq_bench;
  localparam int T_SU_STA = 80;
  localparam int T_HD_STA = 80;
  localparam int T_TURN   = 8;
  localparam int T_LOW    = 168;
  localparam int T_HIGH   = 80;
  localparam int T_SU_STO = 80;
  localparam int T_BUF    = 168;
  localparam int N_PULSES = 9;
  localparam int PERIOD   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic scl_low, sda_low, busy, done;

  always #4 clk = ~clk;

  bus_recover_seq #(
    .T_SU_STA(T_SU_STA), .T_HD_STA(T_HD_STA), .T_TURN(T_TURN), .T_LOW(T_LOW),
    .T_HIGH(T_HIGH), .T_SU_STO(T_SU_STO), .T_BUF(T_BUF), .N_PULSES(N_PULSES)
  ) u_bus_recover_seq (
    .clk(clk), .rst(rst), .req(req),
    .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  default: return "R8";
    endcase
  endfunction

  // Reference model: a queue of expected {scl_low, sda_low, busy, done}.
  logic [3:0] q_val[$];
  int         q_tag[$];
  logic [3:0] exp_v   = 4'b0000;
  int         exp_tag = 1;
  bit         started = 1'b0;

  task automatic put(input int n, input logic [3:0] v, input int t);
    for (int i = 0; i < n; i++) begin
      q_val.push_back(v);
      q_tag.push_back(t);
    end
  endtask

  task automatic build_pattern();
    put(T_SU_STA, 4'b0010, 2);
    put(T_HD_STA, 4'b0110, 3);
    put(T_TURN,   4'b1110, 3);
    for (int p = 0; p < N_PULSES; p++) begin
      put(T_LOW,  4'b1010, 4);
      put(T_HIGH, 4'b0010, 4);
    end
    put(T_SU_STA, 4'b0010, 5);
    put(T_HD_STA, 4'b0110, 5);
    put(T_SU_STO, 4'b0110, 6);
    put(T_BUF,    4'b0010, 7);
    put(1,        4'b0001, 7);
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      q_val.delete();
      q_tag.delete();
      exp_v   = 4'b0000;
      exp_tag = 1;
    end else begin
      if (q_val.size() == 0 && req) build_pattern();
      if (q_val.size() > 0) begin
        exp_v   = q_val.pop_front();
        exp_tag = q_tag.pop_front();
      end else begin
        exp_v   = 4'b0000;
        exp_tag = 8;
      end
    end
  end

  // Per-cycle comparison and bus timing measurement.
  bit prev_scl = 1'b1, prev_sda = 1'b1;
  int since_scl = 1000, since_sda = 1000;
  int starts = 0, pulses = 0;
  bit after_start = 1'b0;
  int dones_seen = 0;

  always @(negedge clk) begin
    if (started) begin
      logic [3:0] act;
      bit scl, sda;
      act = {scl_low, sda_low, busy, done};
      chk(act === exp_v, tag_name(exp_tag), int'(act), int'(exp_v));
      scl = !scl_low;
      sda = !sda_low;
      since_scl++;
      since_sda++;
      if (done) begin
        dones_seen++;
        chk(since_sda * PERIOD >= 1300, "R10", since_sda * PERIOD, 1300); // bus free
      end
      if (!busy) begin
        starts = 0;
        after_start = 1'b0;
      end else begin
        if (scl && !prev_scl) begin
          chk(since_scl * PERIOD >= 1300, "R10", since_scl * PERIOD, 1300); // low time
          if (starts == 1) pulses++;
        end
        if (!scl && prev_scl) begin
          chk(since_scl * PERIOD >= 600, "R10", since_scl * PERIOD, 600); // high time
          if (after_start)
            chk(since_sda * PERIOD >= 600, "R10", since_sda * PERIOD, 600); // start hold
          after_start = 1'b0;
        end
        if (!sda && prev_sda && scl && prev_scl) begin
          chk(since_scl * PERIOD >= 600, "R10", since_scl * PERIOD, 600); // start setup
          if (starts == 1) chk(pulses == N_PULSES, "R4", pulses, N_PULSES);
          starts++;
          pulses = 0;
          after_start = 1'b1;
        end
        if (sda && !prev_sda && scl && prev_scl) begin
          chk(since_sda * PERIOD >= 600, "R10", since_sda * PERIOD, 600); // stop setup
          chk(starts == 2, "R6", starts, 2);
        end
      end
      if (scl != prev_scl) since_scl = 0;
      if (sda != prev_sda) since_sda = 0;
      prev_scl = scl;
      prev_sda = sda;
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic wait_done();
    int d0;
    d0 = dones_seen;
    while (dones_seen == d0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int d0;
    repeat (5) @(negedge clk);
    // R1: reset state at the ports
    chk({scl_low, sda_low, busy, done} === 4'b0000, "R1", int'({scl_low, sda_low, busy, done}), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // Single pulse request (R2..R7)
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R2", int'(busy), 1);
    repeat (500) @(negedge clk);
    // R8: extra request while busy must not disturb the pattern
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R8", int'(busy), 0);

    // R8: request held across done -> back-to-back runs
    req = 1'b1;
    d0 = dones_seen;
    while (dones_seen < d0 + 2) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    wait_done();
    repeat (10) @(negedge clk);

    // R1: reset while both lines are pulled low
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (T_SU_STA + T_HD_STA + 3) @(negedge clk);
    chk({scl_low, sda_low} === 2'b11, "R3", int'({scl_low, sda_low}), 3);
    rst = 1'b1;
    @(negedge clk);
    chk({scl_low, sda_low, busy, done} === 4'b0000, "R1", int'({scl_low, sda_low, busy, done}), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // Fresh run after the mid-pattern reset
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    report();
  end
endmodule